// File: doc/BRIEF.md
# Indirect Serial-Controller Register Bridge

This block sits between a 64-bit host register and the small byte-wide register file of a two-wire serial controller. The host never addresses the controller's registers directly. Instead it writes one command word that carries the following fields:

- a launch flag;
- a two-bit operation class;
- a direction flag;
- a three-bit register code;
- a write byte.

The bridge decodes the target register and waits a fixed number of clocks, which models the path into the controller. It then performs the access and drops the launch flag. After a read, the low byte of the word holds the byte that came back.

The host polls the same word and sees bit 63 as a busy flag until the access finishes. One register code names the clock-control register on a write and the status register on a read. Another code is a soft reset that returns the status register to its idle code. The controller side is modelled as a plain register file. Its configuration registers are brought out so that the serial engine, or a bench, can observe them.

Top module: `twi_indirect_bridge`

## Requirements
- R1: After reset, `host_rdata` is all zero and `ctl_cfg`, `clkdiv_cfg` and `clkctl_cfg` are 0x00. A status read made before any soft reset returns 0x00.
- R2: A host write with bit 63 set launches an access. Bit 63 of `host_rdata` reads 1 for exactly LAT clocks, then 0. The access takes effect in the same clock edge that clears bit 63.
- R3: When an access completes, bits 62:8 of `host_rdata` keep the values the host wrote. Bits 7:0 keep the write byte after a write (bit 56 = 0). After a read (bit 56 = 1), bits 7:0 hold the byte read.
- R4: When bits 59 and 58 are both 1, bits 34:32 select the register: code 1 is the data register, which can be written and read back, and code 2 is the control register, driven on `ctl_cfg`. A write with code 3 loads the clock-control register, driven on `clkctl_cfg`. Configuration outputs change only at the completion edge of an access.
- R5: A read with code 3 (bits 59 and 58 set) returns the status register, never the clock-control register.
- R6: A write with code 7 (bits 59 and 58 set) sets the status register to 0xF8 and clears the data and control registers. A read with code 7 returns 0x00.
- R7: Bit 59 = 1 with bit 58 = 0 selects the 8-bit clock-divisor register, whatever bits 34:32 hold. It is written from bits 7:0, read back, and driven on `clkdiv_cfg`.
- R8: Undefined selections complete normally. These are bit 59 = 0, or codes 0, 4, 5 and 6 with bits 59 and 58 set. A read returns 0x00 in bits 7:0, and a write changes no register.
- R9: A host write while bit 63 of `host_rdata` is 1 is ignored: the running access and the readback word are not changed.
- R10: A host write with bit 63 clear while idle is stored in the readback word but launches no access and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Command word readback: busy flag, fields, result byte |
| ctl_cfg | output | 8 | Control register contents |
| clkdiv_cfg | output | 8 | Clock-divisor register contents |
| clkctl_cfg | output | 8 | Clock-control register contents |

## Verification
The hardest case to reach is a second host write that lands while an access is still in flight. It must leave both the running access and the readback word untouched. The bench reaches it by issuing one write and driving a conflicting command one clock later, inside the busy window. It then proves that the conflicting command was dropped in three ways: the completed word matches the first command, the control output is unchanged, and a read of the data register returns the first command's byte. The shared code 3 is covered by writing clock-control and then reading the same code, which must return the status register before and after a soft reset.

// File: rtl/twi_bridge_pkg.sv
package twi_bridge_pkg;

    localparam int WORD_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int BUSY_B  = 63;
    localparam int CLS_HI  = 59;
    localparam int CLS_LO  = 58;
    localparam int DIR_B   = 56;
    localparam int CODE_LO = 32;
    localparam int CODE_W  = 3;

    localparam logic [BYTE_W-1:0] ST_IDLE  = 8'hF8;
    localparam logic [BYTE_W-1:0] ST_RESET = 8'h00;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DATA,
        TGT_CTL,
        TGT_CLK_STAT,
        TGT_SRST,
        TGT_DIV
    } tgt_e;

    typedef struct packed {
        logic              is_rd;
        tgt_e              tgt;
        logic [BYTE_W-1:0] wbyte;
    } access_t;

    function automatic tgt_e pick_target(input logic cls_hi, input logic cls_lo,
                                         input logic [CODE_W-1:0] code);
        tgt_e t;
        t = TGT_NONE;
        if (cls_hi && cls_lo) begin
            case (code)
                3'd1:    t = TGT_DATA;
                3'd2:    t = TGT_CTL;
                3'd3:    t = TGT_CLK_STAT;
                3'd7:    t = TGT_SRST;
                default: t = TGT_NONE;
            endcase
        end else if (cls_hi) begin
            t = TGT_DIV;
        end
        return t;
    endfunction

endpackage

// File: rtl/twi_cmd_decode.sv
module twi_cmd_decode
    import twi_bridge_pkg::*;
(
    input  logic              cls_hi,
    input  logic              cls_lo,
    input  logic              dir_rd,
    input  logic [CODE_W-1:0] code,
    input  logic [BYTE_W-1:0] wbyte,
    output access_t           acc
);
    always_comb begin
        acc.is_rd = dir_rd;
        acc.tgt   = pick_target(cls_hi, cls_lo, code);
        acc.wbyte = wbyte;
    end
endmodule

// File: rtl/twi_cmd_reg.sv
module twi_cmd_reg
    import twi_bridge_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              acc_is_rd,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [WORD_W-1:0] word,
    output logic              fire
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LAT - 1);

    logic [WORD_W-2:0] body_q;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept;

    assign accept = host_we && !busy_q;
    assign fire   = busy_q && (cnt_q == '0);
    assign word   = {busy_q, body_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            body_q <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            body_q <= host_wdata[WORD_W-2:0];
            busy_q <= host_wdata[BUSY_B];
            cnt_q  <= CNT_INIT;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                if (acc_is_rd)
                    body_q[BYTE_W-1:0] <= rd_byte;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
    import twi_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  access_t           acc,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] ctl_q,
    output logic [BYTE_W-1:0] div_q,
    output logic [BYTE_W-1:0] clkctl_q
);
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] stat_q;
    logic              wr;

    assign wr = fire && !acc.is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            ctl_q    <= '0;
            div_q    <= '0;
            clkctl_q <= '0;
            stat_q   <= ST_RESET;
        end else if (wr) begin
            case (acc.tgt)
                TGT_DATA:     data_q   <= acc.wbyte;
                TGT_CTL:      ctl_q    <= acc.wbyte;
                TGT_CLK_STAT: clkctl_q <= acc.wbyte;
                TGT_DIV:      div_q    <= acc.wbyte;
                TGT_SRST: begin
                    stat_q <= ST_IDLE;
                    data_q <= '0;
                    ctl_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (acc.tgt)
            TGT_DATA:     rd_byte = data_q;
            TGT_CTL:      rd_byte = ctl_q;
            TGT_CLK_STAT: rd_byte = stat_q;
            TGT_DIV:      rd_byte = div_q;
            default:      rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/twi_indirect_bridge.sv
module twi_indirect_bridge
    import twi_bridge_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [63:0] host_wdata,
    output logic [63:0] host_rdata,
    output logic [7:0]  ctl_cfg,
    output logic [7:0]  clkdiv_cfg,
    output logic [7:0]  clkctl_cfg
);
    logic [WORD_W-1:0] word;
    access_t           acc;
    logic              fire;
    logic [BYTE_W-1:0] rd_byte;

    twi_cmd_reg #(.LAT(LAT)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .acc_is_rd  (acc.is_rd),
        .rd_byte    (rd_byte),
        .word       (word),
        .fire       (fire)
    );

    twi_cmd_decode u_dec (
        .cls_hi (word[CLS_HI]),
        .cls_lo (word[CLS_LO]),
        .dir_rd (word[DIR_B]),
        .code   (word[CODE_LO +: CODE_W]),
        .wbyte  (word[BYTE_W-1:0]),
        .acc    (acc)
    );

    twi_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .acc      (acc),
        .rd_byte  (rd_byte),
        .ctl_q    (ctl_cfg),
        .div_q    (clkdiv_cfg),
        .clkctl_q (clkctl_cfg)
    );

    assign host_rdata = word;
endmodule

// File: rtl/twi_bridge_chk.sv
module twi_bridge_chk
    import twi_bridge_pkg::*;
#(
    parameter int LAT = 3
) (
    input logic        clk,
    input logic        rst,
    input logic [63:0] host_rdata,
    input logic [7:0]  ctl_cfg,
    input logic [7:0]  clkdiv_cfg,
    input logic [7:0]  clkctl_cfg
);
    logic [15:0] run_q;
    logic [23:0] cfg;
    tgt_e        tgt_now;

    assign cfg     = {ctl_cfg, clkdiv_cfg, clkctl_cfg};
    assign tgt_now = pick_target(host_rdata[CLS_HI], host_rdata[CLS_LO],
                                 host_rdata[CODE_LO +: CODE_W]);

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (host_rdata[BUSY_B])
            run_q <= (run_q == 16'hFFFF) ? run_q : run_q + 1'b1;
        else
            run_q <= '0;
    end

    AST_BUSY_SHORT: assert property (@(posedge clk) disable iff (rst)
        host_rdata[BUSY_B] |-> run_q < 16'(LAT));  // R2
    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(host_rdata[BUSY_B]) |-> run_q == 16'(LAT));  // R2
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (host_rdata[BUSY_B] && $past(host_rdata[BUSY_B])) |-> $stable(host_rdata));  // R9
    AST_CFG_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $fell(host_rdata[BUSY_B]));  // R4
    AST_UNDEF_WR_NOP: assert property (@(posedge clk) disable iff (rst)
        ($fell(host_rdata[BUSY_B]) && !host_rdata[DIR_B] && tgt_now == TGT_NONE)
            |-> $stable(cfg));  // R8
    AST_UNDEF_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($fell(host_rdata[BUSY_B]) && host_rdata[DIR_B] && tgt_now == TGT_NONE)
            |-> host_rdata[7:0] == 8'h00);  // R8
endmodule

bind twi_indirect_bridge twi_bridge_chk #(.LAT(LAT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_rdata (host_rdata),
    .ctl_cfg    (ctl_cfg),
    .clkdiv_cfg (clkdiv_cfg),
    .clkctl_cfg (clkctl_cfg)
);

// File: tb/sim_twi_indirect_bridge.sv
`timescale 1ns/1ps
module sim_twi_indirect_bridge;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic [7:0]  ctl_cfg, clkdiv_cfg, clkctl_cfg;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    twi_indirect_bridge #(.LAT(LAT)) u0 (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ctl_cfg    (ctl_cfg),
        .clkdiv_cfg (clkdiv_cfg),
        .clkctl_cfg (clkctl_cfg)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // bits 59/58 = 11, code in 34:32, marker 0xC3 in 47:40
    function automatic logic [63:0] ext_cmd(input logic rd, input logic [2:0] code,
                                            input logic [7:0] b);
        logic [63:0] w;
        w = '0;
        w[63] = 1'b1; w[59] = 1'b1; w[58] = 1'b1; w[56] = rd;
        w[47:40] = 8'hC3; w[34:32] = code; w[7:0] = b;
        return w;
    endfunction

    // bit 59 = 1, bit 58 = 0: divisor register; code bits set to prove they are ignored
    function automatic logic [63:0] div_cmd(input logic rd, input logic [7:0] b);
        logic [63:0] w;
        w = '0;
        w[63] = 1'b1; w[59] = 1'b1; w[56] = rd; w[34:32] = 3'd2; w[7:0] = b;
        return w;
    endfunction

    // bit 59 = 0: undefined class
    function automatic logic [63:0] raw_cmd(input logic rd, input logic [7:0] b);
        logic [63:0] w;
        w = '0;
        w[63] = 1'b1; w[56] = rd; w[34:32] = 3'd1; w[7:0] = b;
        return w;
    endfunction

    // driver: launch one access, queue the expected completed word, time the busy window
    task automatic send(input logic [63:0] w, input logic [7:0] rd_exp, input string tag);
        item_t it;
        int n;
        it.exp = {1'b0, w[62:8], (w[56] ? rd_exp : w[7:0])};
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        host_we = 1'b1; host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
        n = 0;
        while (host_rdata[63] && n < 50) begin
            n++;
            @(negedge clk);
        end
        check("R2 busy window", 64'(n), 64'(LAT));
    endtask

    // monitor: pop the scoreboard when the busy flag falls
    bit prev_busy = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_busy && !host_rdata[63]) begin
                if (sb.size() == 0) begin
                    check("R9 unexpected completion", host_rdata, 64'hx);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(it.tag, host_rdata, it.exp);
                end
            end
            prev_busy = host_rdata[63];
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", host_rdata, 64'h0);
        check("R1 cfg", {40'h0, ctl_cfg, clkdiv_cfg, clkctl_cfg}, 64'h0);
        send(ext_cmd(1, 3'd3, 8'h5A), 8'h00, "R1 status before soft reset");

        // R4 data and control, R3 field preservation
        send(ext_cmd(0, 3'd1, 8'hA5), 8'h00, "R3 write word");
        send(ext_cmd(1, 3'd1, 8'h00), 8'hA5, "R4 data readback");
        send(ext_cmd(0, 3'd2, 8'h44), 8'h00, "R4 ctl write");
        check("R4 ctl_cfg", 64'(ctl_cfg), 64'h44);
        send(ext_cmd(1, 3'd2, 8'hFF), 8'h44, "R4 ctl readback");

        // R4/R5 shared code 3
        send(ext_cmd(0, 3'd3, 8'h2B), 8'h00, "R4 clkctl write");
        check("R4 clkctl_cfg", 64'(clkctl_cfg), 64'h2B);
        send(ext_cmd(1, 3'd3, 8'h00), 8'h00, "R5 code3 read gives status");

        // R7 divisor
        send(div_cmd(0, 8'h18), 8'h00, "R7 div write");
        check("R7 clkdiv_cfg", 64'(clkdiv_cfg), 64'h18);
        send(div_cmd(1, 8'h00), 8'h18, "R7 div readback");

        // R6 soft reset
        send(ext_cmd(0, 3'd7, 8'h00), 8'h00, "R6 soft reset");
        check("R6 ctl cleared", 64'(ctl_cfg), 64'h00);
        check("R6 div kept", 64'(clkdiv_cfg), 64'h18);
        send(ext_cmd(1, 3'd3, 8'h00), 8'hF8, "R6 status idle");
        send(ext_cmd(1, 3'd1, 8'h77), 8'h00, "R6 data cleared");
        send(ext_cmd(1, 3'd7, 8'h66), 8'h00, "R6 code7 read zero");

        // R8 undefined selections
        send(ext_cmd(0, 3'd5, 8'h77), 8'h00, "R8 undef code write");
        send(raw_cmd(0, 8'h99), 8'h00, "R8 undef class write");
        check("R8 cfg unchanged", {40'h0, ctl_cfg, clkdiv_cfg, clkctl_cfg}, {40'h0, 8'h00, 8'h18, 8'h2B});
        send(ext_cmd(1, 3'd1, 8'h00), 8'h00, "R8 data untouched");
        send(ext_cmd(1, 3'd5, 8'h99), 8'h00, "R8 undef code read");
        send(raw_cmd(1, 8'h99), 8'h00, "R8 undef class read");
        send(ext_cmd(1, 3'd0, 8'h12), 8'h00, "R8 code0 read");

        // R9 write during busy is dropped
        begin
            item_t it;
            w = ext_cmd(0, 3'd1, 8'h11);
            it.exp = {1'b0, w[62:0]};
            it.tag = "R9 first access intact";
            sb.push_back(it);
            @(negedge clk);
            host_we = 1'b1; host_wdata = w;
            @(negedge clk);
            host_wdata = ext_cmd(0, 3'd2, 8'hEE);
            @(negedge clk);
            host_we = 1'b0;
            repeat (LAT + 2) @(negedge clk);
        end
        check("R9 ctl unchanged", 64'(ctl_cfg), 64'h00);
        send(ext_cmd(1, 3'd1, 8'h00), 8'h11, "R9 data from first");

        // R10 store without launch
        w = ext_cmd(0, 3'd1, 8'h3C);
        w[63] = 1'b0;
        @(negedge clk);
        host_we = 1'b1; host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
        check("R10 stored word", host_rdata, w);
        repeat (LAT + 1) @(negedge clk);
        check("R10 still idle", host_rdata, w);
        send(ext_cmd(1, 3'd1, 8'h00), 8'h11, "R10 no access made");

        repeat (4) @(negedge clk);
        check("R9 scoreboard drained", 64'(sb.size()), 64'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule